// File: doc/BRIEF.md
# Two-Byte Register with Atomic Byte Access

This block holds one 16-bit register and presents it to an 8-bit processor bus as a pair of byte locations. The even address of the pair carries bits 7:0 and the odd address carries bits 15:8. Hardware logic sees the live value on `hw_value`. It also sees two strobes. `hw_acc` marks a software access that counts. `hw_mod` marks a software action that alters the register.

Each of three build options is set independently by a parameter:
- **Staged writes.** A write to the even byte only parks the data in a pending byte. The write to the odd byte then updates all sixteen bits together.
- **Captured reads.** A read of the even byte copies the whole value into a capture register. The following odd-byte read is served from that capture, so a value that hardware or software changes between the two reads cannot tear.
- **Read-clears.** A software read zeroes the register.

The strobes fire only when an update or a capture actually happens, never on the part of a two-step access that is merely staged.

Top module: `wide_reg16`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register takes `RESET_VAL`, the pending byte and the capture register become 0, `bus_rvalid` goes low, and `hw_acc`/`hw_mod` are low while no request is presented.
- R2: With staged writes, a write to the even byte (address bit 0 = 0) leaves `hw_value` unchanged and raises neither strobe.
- R3: With staged writes, a write to the odd byte raises `hw_acc` and `hw_mod` together in the request cycle. From the next cycle `hw_value` = {odd data, pending byte}, and the strobes are low again once the request is gone.
- R4: With staged writes, a second even-byte write before the odd-byte write replaces the pending byte and commits nothing.
- R5: Without staged writes, each byte write raises both strobes in the request cycle and updates only the addressed byte of `hw_value` in the next cycle.
- R6: A read of the pair drives `bus_rvalid` high in the cycle after the request, with the byte on `bus_rdata`. The even address gives bits 7:0 and the odd address gives bits 15:8. A request cycle without a read of the pair gives `bus_rvalid` low in the next cycle.
- R7: With captured reads, an even-byte read stores all 16 bits and returns bits 7:0. An odd-byte read returns bits 15:8 of the last capture, even if the register changed after the capture, and raises no strobe.
- R8: Reads of a register that does not clear on read raise `hw_acc` in the request cycle and never raise `hw_mod`. With captured reads, only the even-byte read raises `hw_acc`.
- R9: With read-clears and captured reads, the even-byte read returns bits 7:0, raises `hw_mod` and `hw_acc` once, and all 16 bits read 0 on `hw_value` in the next cycle. The odd-byte read then returns the captured bits 15:8.
- R10: With read-clears and no capture, each byte read returns that byte, raises both strobes, and zeroes only that byte in the next cycle.
- R11: A request whose address is outside the pair `BASE_ADDR`, `BASE_ADDR`+1 changes nothing and raises no strobe.
- R12: After a reset the pending byte reads as 0, so a lone odd-byte write commits {data, 0x00}. The capture register also reads as 0, so a lone odd-byte read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read of the pair |
| hw_value | output | 16 | Live register value |
| hw_acc | output | 1 | Software access strobe |
| hw_mod | output | 1 | Software modify strobe |

## Verification
The assertions check several properties on every cycle:
- `hw_value` holds still unless `hw_mod` was high in the cycle before.
- An odd-byte commit lands on the next cycle.
- A clearing capture leaves zero behind.
- `bus_rvalid` follows exactly the read requests.
- An odd-byte captured read returns the captured byte.
- `hw_mod` never fires without `hw_acc`.

Some effects are visible only across sequences of accesses, so only the bench scenarios can show them:
- A pending byte is replaced rather than committed.
- A capture survives a later write.
- Reset empties the pending byte and the capture.
- A read-clear splits correctly across two unbuffered byte reads.

The bench runs these scenarios against five option mixes, which share one bus, and compares each against its own model.

// File: rtl/wreg_pkg.sv
// Package: shared widths for the two-byte register block.
// Assumes a register exactly two bus bytes wide.
package wreg_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
endpackage

// File: rtl/wreg_wr_path.sv
// Write path: turns byte writes into per-byte update requests.
// With STAGED=1 the even byte is held until the odd byte arrives, then both
// bytes update together. Assumes at most one write request per cycle.
module wreg_wr_path
    import wreg_pkg::*;
#(
    parameter bit STAGED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic              upd_lo,
    output logic              upd_hi,
    output logic [WORD_W-1:0] upd_data
);
    generate
        if (STAGED) begin : g_staged
            logic [BYTE_W-1:0] pend_q;

            // Hold the most recent even-byte write until the odd byte commits.
            always_ff @(posedge clk) begin
                if (!rst_n)     pend_q <= '0;
                else if (wr_lo) pend_q <= wdata;
            end

            // Both byte lanes update only on the odd-byte write.
            always_comb begin
                upd_lo   = wr_hi;
                upd_hi   = wr_hi;
                upd_data = {wdata, pend_q};
            end

            // R2
            stage_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |-> !(upd_lo || upd_hi));
        end else begin : g_direct
            // Each byte write goes straight to its own lane.
            always_comb begin
                upd_lo   = wr_lo;
                upd_hi   = wr_hi;
                upd_data = {wdata, wdata};
            end

            // R5
            direct_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |-> (upd_lo && !upd_hi));
        end
    endgenerate
endmodule

// File: rtl/wreg_rd_path.sv
// Read path: returns the addressed byte one cycle after the request.
// With CAPTURE=1 an even-byte read copies the whole value and the odd byte
// is served from that copy. It also produces the clear requests for the
// read-clear option. Assumes at most one read request per cycle.
module wreg_rd_path
    import wreg_pkg::*;
#(
    parameter bit CAPTURE   = 1'b1,
    parameter bit READ_CLRS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic [WORD_W-1:0] value,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid,
    output logic              rd_acc,
    output logic              clr_lo,
    output logic              clr_hi
);
    // Raise the valid flag the cycle after any read of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= rd_lo | rd_hi;
    end

    generate
        if (CAPTURE) begin : g_capture
            logic [WORD_W-1:0] snap_q;

            // Copy the full value on an even-byte read.
            always_ff @(posedge clk) begin
                if (!rst_n)     snap_q <= '0;
                else if (rd_lo) snap_q <= value;
            end

            // Return the live low byte or the captured high byte.
            always_ff @(posedge clk) begin
                if (!rst_n)     rdata <= '0;
                else if (rd_lo) rdata <= value[BYTE_W-1:0];
                else if (rd_hi) rdata <= snap_q[WORD_W-1:BYTE_W];
            end

            // Only the capturing read counts as an access or clears.
            always_comb begin
                rd_acc = rd_lo;
                clr_lo = rd_lo & READ_CLRS;
                clr_hi = rd_lo & READ_CLRS;
            end

            // R7
            snap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_hi |=> rdata == $past(snap_q[WORD_W-1:BYTE_W]));
        end else begin : g_live
            // Return the addressed byte of the live value.
            always_ff @(posedge clk) begin
                if (!rst_n)     rdata <= '0;
                else if (rd_lo) rdata <= value[BYTE_W-1:0];
                else if (rd_hi) rdata <= value[WORD_W-1:BYTE_W];
            end

            // Every byte read is an access and clears its own byte.
            always_comb begin
                rd_acc = rd_lo | rd_hi;
                clr_lo = rd_lo & READ_CLRS;
                clr_hi = rd_hi & READ_CLRS;
            end

            // R6
            live_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_hi |=> rdata == $past(value[WORD_W-1:BYTE_W]));
        end
    endgenerate

    // R6
    rvalid_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo || rd_hi) |=> rvalid);
    // R6
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_lo || rd_hi) |=> !rvalid);
endmodule

// File: rtl/wreg_store.sv
// Value store: the 16-bit register and the two hardware strobes.
// Applies per-byte updates from the write path and clears from the read path.
// Assumes an update and a clear never target the same cycle.
module wreg_store
    import wreg_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_lo,
    input  logic              upd_hi,
    input  logic [WORD_W-1:0] upd_data,
    input  logic              clr_lo,
    input  logic              clr_hi,
    input  logic              rd_acc,
    output logic [WORD_W-1:0] value,
    output logic              acc,
    output logic              mod
);
    // Update or clear each byte lane on its own request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RESET_VAL;
        end else begin
            if (upd_lo)      value[BYTE_W-1:0] <= upd_data[BYTE_W-1:0];
            else if (clr_lo) value[BYTE_W-1:0] <= '0;
            if (upd_hi)      value[WORD_W-1:BYTE_W] <= upd_data[WORD_W-1:BYTE_W];
            else if (clr_hi) value[WORD_W-1:BYTE_W] <= '0;
        end
    end

    // Strobes mark the cycle in which a change or access is decided.
    always_comb begin
        mod = upd_lo | upd_hi | clr_lo | clr_hi;
        acc = mod | rd_acc;
    end

    // R3
    hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hi |=> value[WORD_W-1:BYTE_W] == $past(upd_data[WORD_W-1:BYTE_W]));
    // R9
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_lo && clr_hi) |=> value == '0);
    // R2
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mod)) |-> $stable(value));
endmodule

// File: rtl/wide_reg16.sv
// Top: a 16-bit register on an 8-bit bus at BASE_ADDR (even) and BASE_ADDR+1.
// Build options select staged writes, captured reads and read-clear.
// Assumes one bus request per cycle and BASE_ADDR even.
module wide_reg16
    import wreg_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 4'h6,
    parameter bit                STAGED    = 1'b1,
    parameter bit                CAPTURE   = 1'b1,
    parameter bit                READ_CLRS = 1'b0,
    parameter logic [WORD_W-1:0] RESET_VAL = 16'h1234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [WORD_W-1:0] hw_value,
    output logic              hw_acc,
    output logic              hw_mod
);
    localparam logic [ADDR_W-2:0] PAIR = BASE_ADDR[ADDR_W-1:1];

    logic hit, wr_lo, wr_hi, rd_lo, rd_hi;
    logic upd_lo, upd_hi, clr_lo, clr_hi, rd_acc;
    logic [WORD_W-1:0] upd_data;

    // Decode the byte pair and the lane from the address.
    always_comb begin
        hit   = bus_req && (bus_addr[ADDR_W-1:1] == PAIR);
        wr_lo = hit &&  bus_we && !bus_addr[0];
        wr_hi = hit &&  bus_we &&  bus_addr[0];
        rd_lo = hit && !bus_we && !bus_addr[0];
        rd_hi = hit && !bus_we &&  bus_addr[0];
    end

    wreg_wr_path #(.STAGED(STAGED)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(bus_wdata), .upd_lo(upd_lo), .upd_hi(upd_hi), .upd_data(upd_data)
    );

    wreg_rd_path #(.CAPTURE(CAPTURE), .READ_CLRS(READ_CLRS)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi), .value(hw_value),
        .rdata(bus_rdata), .rvalid(bus_rvalid), .rd_acc(rd_acc),
        .clr_lo(clr_lo), .clr_hi(clr_hi)
    );

    wreg_store #(.RESET_VAL(RESET_VAL)) u_store (
        .clk(clk), .rst_n(rst_n), .upd_lo(upd_lo), .upd_hi(upd_hi),
        .upd_data(upd_data), .clr_lo(clr_lo), .clr_hi(clr_hi), .rd_acc(rd_acc),
        .value(hw_value), .acc(hw_acc), .mod(hw_mod)
    );

    // R8
    mod_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mod |-> hw_acc);
    // R11
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !(hw_acc || hw_mod));
endmodule

// File: tb/tb_wide_reg16.sv
module tb_wide_reg16;
    localparam int NC = 5;
    localparam logic [3:0] BASE = 4'h6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0]  rdata_a [NC];
    logic        rvalid_a[NC];
    logic [15:0] val_a   [NC];
    logic        acc_a   [NC];
    logic        mod_a   [NC];

    always #5 clk = ~clk;

    // Option mixes: 0 staged+capture, 1 staged, 2 capture+clear, 3 none, 4 clear
    function automatic bit c_wb(int c);  return c < 2;            endfunction
    function automatic bit c_rb(int c);  return c == 0 || c == 2; endfunction
    function automatic bit c_cor(int c); return c == 2 || c == 4; endfunction
    function automatic logic [15:0] c_rst(int c);
        case (c)
            0: return 16'h1234;
            1: return 16'hABCD;
            2: return 16'h1030;
            3: return 16'h00FF;
            default: return 16'h1030;
        endcase
    endfunction

    for (genvar i = 0; i < NC; i++) begin : g
        wide_reg16 #(
            .ADDR_W(4), .BASE_ADDR(BASE), .STAGED(c_wb(i)), .CAPTURE(c_rb(i)),
            .READ_CLRS(c_cor(i)), .RESET_VAL(c_rst(i))
        ) dut (
            .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a[i]),
            .bus_rvalid(rvalid_a[i]), .hw_value(val_a[i]), .hw_acc(acc_a[i]),
            .hw_mod(mod_a[i])
        );
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] m_val[NC], m_pend[NC], m_snap[NC];

    task automatic chk(string req, int c, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cfg%0d: actual 0x%0h expected 0x%0h", req, c, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin
            m_val[c] = c_rst(c); m_pend[c] = '0; m_snap[c] = '0;
        end
    endtask

    // Called just after a falling edge; drives one request and checks both sides.
    task automatic op(bit we, logic [3:0] addr, logic [7:0] d);
        bit e_acc[NC], e_mod[NC], e_rv[NC];
        logic [7:0] e_rd[NC];
        string tag[NC];
        bit hit, hi;
        hit = (addr[3:1] == BASE[3:1]);
        hi  = addr[0];
        bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = d;
        for (int c = 0; c < NC; c++) begin
            e_acc[c] = 0; e_mod[c] = 0; e_rv[c] = 0; e_rd[c] = '0;
            if (!hit) tag[c] = "R11";
            else if (we) begin
                if (c_wb(c)) begin
                    if (!hi) begin
                        tag[c] = "R2";
                        m_pend[c] = {8'h00, d};
                    end else begin
                        tag[c] = "R3";
                        m_val[c] = {d, m_pend[c][7:0]};
                        e_acc[c] = 1; e_mod[c] = 1;
                    end
                end else begin
                    tag[c] = "R5";
                    if (hi) m_val[c][15:8] = d; else m_val[c][7:0] = d;
                    e_acc[c] = 1; e_mod[c] = 1;
                end
            end else begin
                e_rv[c] = 1;
                if (c_rb(c)) begin
                    tag[c] = c_cor(c) ? "R9" : "R7";
                    if (!hi) begin
                        e_rd[c] = m_val[c][7:0];
                        m_snap[c] = m_val[c];
                        e_acc[c] = 1;
                        if (c_cor(c)) begin m_val[c] = '0; e_mod[c] = 1; end
                    end else begin
                        e_rd[c] = m_snap[c][15:8];
                    end
                end else begin
                    tag[c] = c_cor(c) ? "R10" : "R8";
                    e_rd[c] = hi ? m_val[c][15:8] : m_val[c][7:0];
                    e_acc[c] = 1;
                    if (c_cor(c)) begin
                        e_mod[c] = 1;
                        if (hi) m_val[c][15:8] = '0; else m_val[c][7:0] = '0;
                    end
                end
            end
        end
        #1;
        for (int c = 0; c < NC; c++) begin
            chk(tag[c], c, 16'(acc_a[c]), 16'(e_acc[c]));
            chk(tag[c], c, 16'(mod_a[c]), 16'(e_mod[c]));
        end
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        for (int c = 0; c < NC; c++) begin
            chk(tag[c], c, val_a[c], m_val[c]);
            chk("R6", c, 16'(rvalid_a[c]), 16'(e_rv[c]));
            if (e_rv[c]) chk("R6", c, 16'(rdata_a[c]), 16'(e_rd[c]));
            chk(tag[c], c, 16'(acc_a[c]), 16'h0);
            chk(tag[c], c, 16'(mod_a[c]), 16'h0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_req = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        for (int c = 0; c < NC; c++) begin
            chk("R1", c, val_a[c], c_rst(c));
            chk("R1", c, 16'(rvalid_a[c]), 16'h0);
            chk("R1", c, 16'(acc_a[c]), 16'h0);
            chk("R1", c, 16'(mod_a[c]), 16'h0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // Read-clear first, while the reset values are intact.
        op(0, 4'h6, 8'h00);
        chk("R9", 2, 16'(rdata_a[2]), 16'h0030);
        chk("R9", 2, val_a[2], 16'h0000);
        chk("R10", 4, val_a[4], 16'h1000);
        op(0, 4'h7, 8'h00);
        chk("R9", 2, 16'(rdata_a[2]), 16'h0010);
        chk("R10", 4, 16'(rdata_a[4]), 16'h0010);
        chk("R10", 4, val_a[4], 16'h0000);
        // Staged commit of 0x67 then 0x45.
        op(1, 4'h6, 8'h67);
        chk("R2", 0, val_a[0], 16'h1234);
        op(1, 4'h7, 8'h45);
        chk("R3", 0, val_a[0], 16'h4567);
        // Pending byte replaced before commit.
        op(1, 4'h6, 8'h11);
        op(1, 4'h6, 8'h22);
        chk("R4", 1, val_a[1], 16'h4567);
        op(1, 4'h7, 8'h33);
        chk("R4", 1, val_a[1], 16'h3322);
        // Capture survives a later write.
        op(0, 4'h6, 8'h00);
        op(1, 4'h6, 8'hAA);
        op(1, 4'h7, 8'hBB);
        op(0, 4'h7, 8'h00);
        chk("R7", 0, 16'(rdata_a[0]), 16'h0033);
        // Outside the pair.
        op(1, 4'h3, 8'h5C);
        op(0, 4'h8, 8'h00);
        // Random mix biased toward the pair.
        for (int k = 0; k < 400; k++) begin
            logic [3:0] a;
            a = ($urandom % 10 < 7) ? {BASE[3:1], 1'($urandom)} : 4'($urandom);
            op(1'($urandom), a, 8'($urandom));
        end
        // Reset empties the pending byte and the capture.
        op(1, 4'h6, 8'hEE);
        op(0, 4'h6, 8'h00);
        do_reset();
        op(1, 4'h7, 8'h5A);
        chk("R12", 0, val_a[0], 16'h5A00);
        chk("R12", 1, val_a[1], 16'h5A00);
        op(0, 4'h7, 8'h00);
        chk("R12", 0, 16'(rdata_a[0]), 16'h0000);
        chk("R12", 2, 16'(rdata_a[2]), 16'h0000);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule